// File: doc/BRIEF.md
# Mode-Dependent Bidirectional Port Controller

This block controls an 8-bit bidirectional pin group. Each pin can carry one bit of the upper address byte, act as a general output, or act as a general input. A 2-bit operating mode and a per-pin direction register decide which role each pin takes. Three byte-wide registers sit on a simple peripheral bus:

- a direction register;
- a data register;
- a pull-up control register.

The controller drives output enables, output values and pull-up enables for the pads. It also brings the pad input levels into the clock domain through a two-flop synchronizer.

The operating mode is captured on the first clock after reset is released and is then held. Hardware standby behaves differently from software standby:

- Hardware standby floats every pin and clears the direction register.
- Software standby leaves every register and every pin state as it is.

The upper address byte arrives as a plain input bus.

Top module: `port_ctl`

## Requirements
- R1: Registers decode at fixed bus addresses: direction at 0xFFB1, data at 0xFFB3, pull-up control at 0xFFAD. Data and pull-up control reset to 0x00 and read back what was written. A write lands on the clock edge where the write strobe is high.
- R2: In mode code 1, every pin drives the upper address byte and every output enable is 1. Writes to the direction register have no effect on the pins.
- R3: While hardware standby is high, every output enable and every pull-up enable is 0, in every mode.
- R4: In mode code 2, a pin whose direction bit is 1 drives its upper address bit. A pin whose direction bit is 0 is an undriven general input.
- R5: In mode codes 3 and 0, a pin whose direction bit is 1 drives its data register bit. A pin whose direction bit is 0 is an undriven general input.
- R6: A read of the direction register address always returns 0xFF, whatever the register holds.
- R7: The direction register is 0x00 after reset. Hardware standby clears it, so pins stay undriven after standby ends.
- R8: Software standby changes no register and no pin output, output enable or pull-up enable.
- R9: A read of the data register returns the latched bit for pins that are general outputs. For all other pins it returns the pin level two clock edges after that level is applied.
- R10: A pull-up enable is 1 exactly when its control bit is 1, the pin is not driven, and hardware standby is low.
- R11: A read of any other address returns 0x00.
- R12: The mode input is captured at the first clock after reset release. Later changes to the mode input have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode code, captured after reset |
| hw_stby_i | input | 1 | Hardware standby |
| sw_stby_i | input | 1 | Software standby |
| addr_i | input | 16 | Bus address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current address |
| addr_hi_i | input | 8 | Upper address byte to be driven out |
| pin_in_i | input | 8 | Pad input levels |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_out_o | output | 8 | Per-pin output value |
| pin_pu_o | output | 8 | Per-pin pull-up enable |

## Verification
The bench builds the block with its default parameters: an 8-pin port, a 16-bit bus address, and the three register addresses given in R1. With an 8-bit port, the bench can check every pin with full-byte patterns such as 0x0F, 0xF0 and 0x5A. Those patterns separate driven pins from input pins within one byte, in each of the three mode codes. The 16-bit address lets the bench reach both the mapped registers and an unmapped address.

// File: rtl/port_ctl.sv
module port_ctl #(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] A_DIR = 16'hFFB1,
  parameter logic [AW-1:0] A_DAT = 16'hFFB3,
  parameter logic [AW-1:0] A_PU  = 16'hFFAD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          hw_stby_i,
  input  logic          sw_stby_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [W-1:0]  addr_hi_i,
  input  logic [W-1:0]  pin_in_i,
  output logic [W-1:0]  pin_oe_o,
  output logic [W-1:0]  pin_out_o,
  output logic [W-1:0]  pin_pu_o
);
  logic [W-1:0] dir_q, dat_q, pu_q, s1_q, s2_q;
  logic [1:0]   mode_q;
  logic         started;
  logic [1:0]   mode;
  logic         m_addr, m_mixed, m_gpio;
  logic [W-1:0] gp_out;

  assign mode    = started ? mode_q : mode_i;
  assign m_addr  = (mode == 2'd1);
  assign m_mixed = (mode == 2'd2);
  assign m_gpio  = !m_addr && !m_mixed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      started <= 1'b0;
      mode_q  <= 2'd0;
    end else if (!started) begin
      started <= 1'b1;
      mode_q  <= mode_i;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      pu_q  <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
    end else begin
      s1_q <= pin_in_i;
      s2_q <= s1_q;
      if (hw_stby_i) dir_q <= '0;
      else if (wr_i && addr_i == A_DIR && !m_addr) dir_q <= wdata_i;
      if (wr_i && addr_i == A_DAT) dat_q <= wdata_i;
      if (wr_i && addr_i == A_PU)  pu_q  <= wdata_i;
    end

  assign gp_out    = m_gpio ? dir_q : '0;
  assign pin_oe_o  = hw_stby_i ? '0 : (m_addr ? '1 : dir_q);
  assign pin_out_o = m_gpio ? dat_q : addr_hi_i;
  assign pin_pu_o  = pu_q & ~pin_oe_o & {W{!hw_stby_i}};

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_DIR)      rdata_o = '1;
    else if (addr_i == A_DAT) rdata_o = (dat_q & gp_out) | (s2_q & ~gp_out);
    else if (addr_i == A_PU)  rdata_o = pu_q;
  end

  p_hw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby_i |=> dir_q == '0);
  p_sw_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby_i && !hw_stby_i && !wr_i) |=> ($stable(dir_q) && $stable(dat_q) && $stable(pu_q)));
  p_pu_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu_o & pin_oe_o) == '0);
  p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> $stable(mode_q));
  p_dir_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode_q == 2'd1 && !hw_stby_i) |=> $stable(dir_q));
  p_hw_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby_i |-> (pin_oe_o == '0 && pin_pu_o == '0));
endmodule

// File: tb/test_port_ctl.sv
module test_port_ctl;
  logic clk = 0, rst_n = 0, hw = 0, sw = 0, wr = 0;
  logic [1:0] mode = 2'd1;
  logic [15:0] addr = 16'h0000;
  logic [7:0] wd = 0, ahi = 8'hA5, pin = 0;
  logic [7:0] rd, oe, po, pu;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  port_ctl i_port_ctl (.clk(clk), .rst_n(rst_n), .mode_i(mode), .hw_stby_i(hw),
    .sw_stby_i(sw), .addr_i(addr), .wr_i(wr), .wdata_i(wd), .rdata_o(rd),
    .addr_hi_i(ahi), .pin_in_i(pin), .pin_oe_o(oe), .pin_out_o(po), .pin_pu_o(pu));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] m);
    @(negedge clk); rst_n = 0; mode = m; hw = 0; sw = 0; wr = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wreg(logic [15:0] a, logic [7:0] d);
    addr = a; wd = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [15:0] a, output logic [7:0] d);
    addr = a; #1 d = rd;
  endtask

  task automatic t_mode1;
    logic [7:0] v;
    do_reset(2'd1);
    chk("R2 oe", oe, 8'hFF);
    chk("R2 out", po, 8'hA5);
    rreg(16'hFFB3, v); chk("R1 data reset", v, 8'h00);
    rreg(16'hFFAD, v); chk("R1 pu reset", v, 8'h00);
    wreg(16'hFFB1, 8'h00);
    chk("R2 dir write ignored", oe, 8'hFF);
    rreg(16'hFFB1, v); chk("R6 dir read m1", v, 8'hFF);
    wreg(16'hFFAD, 8'hFF);
    chk("R10 no pu when driven", pu, 8'h00);
    mode = 2'd3; @(negedge clk);
    chk("R12 mode held", oe, 8'hFF);
    chk("R12 out held", po, 8'hA5);
    hw = 1; #1;
    chk("R3 m1 float", oe, 8'h00);
    chk("R3 m1 pu", pu, 8'h00);
    @(negedge clk); hw = 0;
  endtask

  task automatic t_mode2;
    logic [7:0] v;
    do_reset(2'd2);
    chk("R7 dir reset", oe, 8'h00);
    wreg(16'hFFB1, 8'h0F);
    wreg(16'hFFAD, 8'hFF);
    chk("R4 oe", oe, 8'h0F);
    chk("R4 out", po & oe, 8'h05);
    chk("R10 pu inputs", pu, 8'hF0);
    rreg(16'hFFB1, v); chk("R6 dir read m2", v, 8'hFF);
    pin = 8'h3C; @(negedge clk); @(negedge clk);
    rreg(16'hFFB3, v); chk("R9 m2 pins", v, 8'h3C);
    rreg(16'h1234, v); chk("R11 unmapped", v, 8'h00);
  endtask

  task automatic t_mode3;
    logic [7:0] v;
    do_reset(2'd3);
    wreg(16'hFFB1, 8'hF0);
    wreg(16'hFFB3, 8'h5A);
    wreg(16'hFFAD, 8'h33);
    pin = 8'h03; @(negedge clk); @(negedge clk);
    chk("R5 oe", oe, 8'hF0);
    chk("R5 out", po & oe, 8'h50);
    rreg(16'hFFB3, v); chk("R9 mixed read", v, 8'h53);
    rreg(16'hFFAD, v); chk("R1 pu readback", v, 8'h33);
    chk("R10 pu", pu, 8'h03);
    sw = 1; @(negedge clk); @(negedge clk);
    chk("R8 oe kept", oe, 8'hF0);
    chk("R8 out kept", po & oe, 8'h50);
    chk("R8 pu kept", pu, 8'h03);
    sw = 0;
    hw = 1; #1;
    chk("R3 m3 float", oe, 8'h00);
    chk("R3 m3 pu", pu, 8'h00);
    @(negedge clk); hw = 0; #1;
    chk("R7 dir cleared", oe, 8'h00);
    chk("R10 pu after clear", pu, 8'h33);
    rreg(16'hFFB3, v); chk("R9 all input", v, 8'h03);
  endtask

  initial begin
    fork
      begin t_mode1; t_mode2; t_mode3; end
      begin repeat (5000) @(posedge clk); n_run++; n_fail++; $display("FAIL watchdog"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule